// File: doc/BRIEF.md
# Super I/O Configuration Mode Controller

This block guards the configuration space of a Super I/O style device that sits on a simple host byte bus. After reset the device is in a normal operating state, and the configuration registers are hidden. A host opens them by writing an unlock key to a fixed configuration port. While the space is open, that same port takes a register index and the address one above it carries the data. A lock key written to the configuration port closes the space again.

Registers with an index below 0x30 are global. One of them is the logical-device selector at index 0x07. Registers at 0x30 and above are banked by the device number held in that selector. This block implements the chip identity bytes and the hardware-monitor base address. The base address lives in logical device 8 and is driven out continuously, so the monitor's address decoder can use it.

Top module: `sio_cfg_ctrl`

## Requirements
- R1: After reset the block is locked (`cfg_active` = 0), `mon_base` = 0x0480, and the index and device selector are both 0x00.
- R2: While locked, a write of 0x55 to address 0x002E unlocks the block, and `cfg_active` is 1 from the following clock edge.
- R3: While locked, every other write has no effect on `cfg_active` or `mon_base`, and every read returns 0xFF. This covers other values written to 0x002E and any value written to 0x002F.
- R4: While unlocked, a write of 0xAA to 0x002E locks the block again. `cfg_active` is 0 from the following edge, and the stored register contents are kept.
- R5: While unlocked, a write of any other value to 0x002E, including 0x55, loads the index. A read of 0x002E returns the current index.
- R6: With index 0x07, a write to 0x002F loads the device selector, and a read of 0x002F returns it.
- R7: With index 0x20 a read of 0x002F returns 0x6F, and with index 0x21 it returns 0x01. Both hold whatever the device selector is, and writes to these indices change nothing.
- R8: With device selector 0x08, index 0x60 reads and writes bits 15:8 of the base address and index 0x61 reads and writes bits 7:0. A write appears on `mon_base` from the following edge.
- R9: With any other device selector, writes to indices 0x60 and 0x61 leave `mon_base` unchanged, and reads at those indices return 0x00.
- R10: While unlocked, a data read at an index that has no register returns 0x00. A read of any address other than 0x002E and 0x002F returns 0xFF in either state.
- R11: `bus_rdata` is combinational on the read strobe, and it is 0xFF whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Host bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| cfg_active | output | 1 | High while the configuration space is unlocked |
| mon_base | output | 16 | Hardware-monitor base address |

## Verification
The hardest state to reach from the ports is a write that actually lands in the base address. It needs five ordered bus writes: the unlock key, index 0x07, device 8, index 0x60 or 0x61, and then the data. An 0xAA written to the index port anywhere in that chain breaks it. The random stimulus therefore biases both the written values and the addresses toward the keys, the selector index, device 8 and the base indices, so the chain forms many times. Directed sequences cover the same path explicitly, including the case where the selector holds another device.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        MODE_RUN = 1'b0,
        MODE_CFG = 1'b1
    } sio_mode_e;

    localparam byte_t READ_IDLE  = 8'hFF;
    localparam byte_t READ_EMPTY = 8'h00;
endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CFG_PORT = 16'h002E
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              idx_wr,
    output logic              dat_wr,
    output logic              idx_rd,
    output logic              dat_rd
);
    localparam logic [ADDR_W-1:0] DAT_PORT = CFG_PORT + 1'b1;

    logic hit_idx;
    logic hit_dat;

    always_comb begin
        hit_idx = (addr == CFG_PORT);
        hit_dat = (addr == DAT_PORT);
        idx_wr  = wr & hit_idx;
        dat_wr  = wr & hit_dat;
        idx_rd  = rd & hit_idx;
        dat_rd  = rd & hit_dat;
    end
endmodule

// File: rtl/sio_mode_fsm.sv
module sio_mode_fsm
    import sio_cfg_pkg::*;
#(
    parameter byte_t ENTER_KEY = 8'h55,
    parameter byte_t EXIT_KEY  = 8'hAA
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  idx_wr,
    input  byte_t wdata,
    output logic  cfg_active,
    output logic  idx_load
);
    typedef struct packed {
        sio_mode_e mode;
    } mode_state_t;

    mode_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        idx_load = 1'b0;
        unique case (st_q.mode)
            MODE_RUN: begin
                if (idx_wr && wdata == ENTER_KEY) begin
                    st_d.mode = MODE_CFG;
                end
            end
            MODE_CFG: begin
                if (idx_wr) begin
                    if (wdata == EXIT_KEY) begin
                        st_d.mode = MODE_RUN;
                    end else begin
                        idx_load = 1'b1;
                    end
                end
            end
            default: st_d.mode = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_active = (st_q.mode == MODE_CFG);
endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank
    import sio_cfg_pkg::*;
#(
    parameter byte_t  LDN_IDX      = 8'h07,
    parameter byte_t  ID_IDX       = 8'h20,
    parameter byte_t  REV_IDX      = 8'h21,
    parameter byte_t  DEV_ID       = 8'h6F,
    parameter byte_t  DEV_REV      = 8'h01,
    parameter byte_t  BANK_FLOOR   = 8'h30,
    parameter byte_t  MON_LDN      = 8'h08,
    parameter byte_t  MON_IDX      = 8'h60,
    parameter int     MON_BYTES    = 2,
    parameter logic [MON_BYTES*BYTE_W-1:0] MON_RST = 16'h0480
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cfg_active,
    input  logic  idx_load,
    input  logic  dat_wr,
    input  logic  idx_rd,
    input  logic  dat_rd,
    input  byte_t wdata,
    output byte_t rdata,
    output byte_t cur_index,
    output byte_t cur_ldn,
    output logic [MON_BYTES*BYTE_W-1:0] mon_base
);
    localparam int MON_W = MON_BYTES * BYTE_W;

    typedef struct packed {
        byte_t              index;
        byte_t              ldn;
        logic [MON_W-1:0]   base;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic  is_banked;
    logic  mon_sel;
    logic  [MON_BYTES-1:0] base_hit;
    byte_t base_rd;

    // One index per base byte; the lowest index holds the most significant byte.
    genvar g;
    generate
        for (g = 0; g < MON_BYTES; g++) begin : g_base_hit
            localparam byte_t THIS_IDX = MON_IDX + byte_t'(g);
            assign base_hit[g] = (st_q.index == THIS_IDX);
        end
    endgenerate

    always_comb begin
        is_banked = (st_q.index >= BANK_FLOOR);
        mon_sel   = is_banked && (st_q.ldn == MON_LDN);
        base_rd   = READ_EMPTY;
        for (int i = 0; i < MON_BYTES; i++) begin
            if (mon_sel && base_hit[i]) begin
                base_rd = st_q.base[(MON_BYTES-1-i)*BYTE_W +: BYTE_W];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (idx_load) begin
            st_d.index = wdata;
        end
        if (cfg_active && dat_wr) begin
            if (st_q.index == LDN_IDX) begin
                st_d.ldn = wdata;
            end
            for (int i = 0; i < MON_BYTES; i++) begin
                if (mon_sel && base_hit[i]) begin
                    st_d.base[(MON_BYTES-1-i)*BYTE_W +: BYTE_W] = wdata;
                end
            end
        end
    end

    always_comb begin
        rdata = READ_IDLE;
        if (cfg_active) begin
            if (idx_rd) begin
                rdata = st_q.index;
            end else if (dat_rd) begin
                if (st_q.index == LDN_IDX) begin
                    rdata = st_q.ldn;
                end else if (st_q.index == ID_IDX) begin
                    rdata = DEV_ID;
                end else if (st_q.index == REV_IDX) begin
                    rdata = DEV_REV;
                end else begin
                    rdata = base_rd;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.index <= '0;
            st_q.ldn   <= '0;
            st_q.base  <= MON_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_index = st_q.index;
    assign cur_ldn   = st_q.ldn;
    assign mon_base  = st_q.base;
endmodule

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
    import sio_cfg_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CFG_PORT = 16'h002E,
    parameter byte_t           ENTER_KEY = 8'h55,
    parameter byte_t           EXIT_KEY  = 8'hAA,
    parameter byte_t           DEV_ID    = 8'h6F,
    parameter byte_t           DEV_REV   = 8'h01,
    parameter byte_t           MON_LDN   = 8'h08,
    parameter int              MON_BYTES = 2,
    parameter logic [MON_BYTES*8-1:0] MON_RST = 16'h0480
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [7:0]               bus_wdata,
    output logic [7:0]               bus_rdata,
    output logic                     cfg_active,
    output logic [MON_BYTES*8-1:0]   mon_base
);
    logic  idx_wr, dat_wr, idx_rd, dat_rd;
    logic  idx_load;
    byte_t cfg_index;
    byte_t cfg_ldn;

    sio_port_decode #(
        .ADDR_W   (ADDR_W),
        .CFG_PORT (CFG_PORT)
    ) u_decode (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .idx_wr (idx_wr),
        .dat_wr (dat_wr),
        .idx_rd (idx_rd),
        .dat_rd (dat_rd)
    );

    sio_mode_fsm #(
        .ENTER_KEY (ENTER_KEY),
        .EXIT_KEY  (EXIT_KEY)
    ) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_wr     (idx_wr),
        .wdata      (bus_wdata),
        .cfg_active (cfg_active),
        .idx_load   (idx_load)
    );

    sio_reg_bank #(
        .DEV_ID    (DEV_ID),
        .DEV_REV   (DEV_REV),
        .MON_LDN   (MON_LDN),
        .MON_BYTES (MON_BYTES),
        .MON_RST   (MON_RST)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_active (cfg_active),
        .idx_load   (idx_load),
        .dat_wr     (dat_wr),
        .idx_rd     (idx_rd),
        .dat_rd     (dat_rd),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .cur_index  (cfg_index),
        .cur_ldn    (cfg_ldn),
        .mon_base   (mon_base)
    );
endmodule

// File: rtl/sio_cfg_checker.sv
module sio_cfg_checker #(
    parameter logic [15:0] CFG_PORT = 16'h002E
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic        cfg_active,
    input logic [15:0] mon_base,
    input logic [7:0]  cfg_index,
    input logic [7:0]  cfg_ldn
);
    localparam logic [15:0] DAT_PORT = CFG_PORT + 16'd1;

    logic enter_wr;
    logic exit_wr;
    logic dat_access;
    assign enter_wr   = bus_wr && bus_addr == CFG_PORT && bus_wdata == 8'h55;
    assign exit_wr    = bus_wr && bus_addr == CFG_PORT && bus_wdata == 8'hAA;
    assign dat_access = cfg_active && bus_wr && bus_addr == DAT_PORT;

    a_r2_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_active && enter_wr |=> cfg_active);

    a_r3_stay_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_active && !enter_wr |=> !cfg_active);

    a_r3_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_active |=> $stable(mon_base));

    a_r3_locked_reads: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_active |-> bus_rdata == 8'hFF);

    a_r4_lock: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_active && exit_wr |=> !cfg_active);

    a_r8_msb_write: assert property (@(posedge clk) disable iff (!rst_n)
        dat_access && cfg_index == 8'h60 && cfg_ldn == 8'h08
        |=> mon_base[15:8] == $past(bus_wdata));

    a_r9_other_ldn: assert property (@(posedge clk) disable iff (!rst_n)
        dat_access && cfg_ldn != 8'h08 |=> $stable(mon_base));

    a_r11_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == 8'hFF);
endmodule

bind sio_cfg_ctrl sio_cfg_checker #(.CFG_PORT(16'h002E)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cfg_active (cfg_active),
    .mon_base   (mon_base),
    .cfg_index  (cfg_index),
    .cfg_ldn    (cfg_ldn)
);

// File: tb/sio_cfg_ctrl_test.sv
module sio_cfg_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        cfg_active;
    logic [15:0] mon_base;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Reference model state
    bit          m_cfg;
    logic [7:0]  m_idx;
    logic [7:0]  m_ldn;
    logic [15:0] m_base;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_cfg_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cfg_active (cfg_active),
        .mon_base   (mon_base)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        if (!m_cfg) return 8'hFF;
        if (a == 16'h002E) return m_idx;
        if (a != 16'h002F) return 8'hFF;
        case (m_idx)
            8'h07: return m_ldn;
            8'h20: return 8'h6F;
            8'h21: return 8'h01;
            8'h60: return (m_ldn == 8'h08) ? m_base[15:8] : 8'h00;
            8'h61: return (m_ldn == 8'h08) ? m_base[7:0] : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_write(input logic [15:0] a, input logic [7:0] d);
        if (a == 16'h002E) begin
            if (!m_cfg) begin
                if (d == 8'h55) m_cfg = 1'b1;
            end else if (d == 8'hAA) begin
                m_cfg = 1'b0;
            end else begin
                m_idx = d;
            end
        end else if (a == 16'h002F && m_cfg) begin
            if (m_idx == 8'h07) m_ldn = d;
            else if (m_idx == 8'h60 && m_ldn == 8'h08) m_base[15:8] = d;
            else if (m_idx == 8'h61 && m_ldn == 8'h08) m_base[7:0] = d;
        end
    endfunction

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(input string req, input logic [15:0] a);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #(CLK_PERIOD/4);
        check(req, bus_rdata, exp_read(a));
        bus_rd = 1'b0;
    endtask

    task automatic check_outputs(input string req);
        check({req, " cfg_active"}, cfg_active, m_cfg);
        check({req, " mon_base"}, mon_base, m_base);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_cfg = 1'b0; m_idx = 8'h00; m_ldn = 8'h00; m_base = 16'h0480;
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_outputs("R1");
        #1;
        check("R11 idle rdata", bus_rdata, 8'hFF);

        // R3 locked: ignored writes and 0xFF reads
        bus_write(16'h002E, 8'h07);
        bus_write(16'h002F, 8'h08);
        bus_write(16'h002E, 8'hAA);
        check_outputs("R3");
        bus_read("R3 locked index read", 16'h002E);
        bus_read("R3 locked data read", 16'h002F);

        // R2 unlock, R5 index readback
        bus_write(16'h002E, 8'h55);
        check("R2 unlock", cfg_active, 1'b1);
        bus_write(16'h002E, 8'h20);
        bus_read("R5 index read", 16'h002E);
        bus_read("R7 device id", 16'h002F);
        bus_write(16'h002F, 8'h12);
        bus_read("R7 id write ignored", 16'h002F);
        bus_write(16'h002E, 8'h21);
        bus_read("R7 revision", 16'h002F);

        // R9 base with another device selected
        bus_write(16'h002E, 8'h07);
        bus_write(16'h002F, 8'h03);
        bus_read("R6 ldn read", 16'h002F);
        bus_write(16'h002E, 8'h60);
        bus_write(16'h002F, 8'h9C);
        check("R9 base unchanged", mon_base, 16'h0480);
        bus_read("R9 read 0x00", 16'h002F);

        // R8 base in device 8
        bus_write(16'h002E, 8'h07);
        bus_write(16'h002F, 8'h08);
        bus_write(16'h002E, 8'h60);
        bus_read("R8 msb reset value", 16'h002F);
        bus_write(16'h002F, 8'h0A);
        check("R8 msb write", mon_base, 16'h0A80);
        bus_write(16'h002E, 8'h61);
        bus_write(16'h002F, 8'h5D);
        check("R8 lsb write", mon_base, 16'h0A5D);
        bus_read("R8 lsb read", 16'h002F);

        // R10 empty index and undecoded address
        bus_write(16'h002E, 8'h33);
        bus_read("R10 empty index", 16'h002F);
        bus_read("R10 undecoded addr", 16'h0480);

        // R5 0x55 inside config loads the index
        bus_write(16'h002E, 8'h55);
        check("R5 key as index keeps mode", cfg_active, 1'b1);
        bus_read("R5 key as index", 16'h002E);

        // R4 lock keeps contents
        bus_write(16'h002E, 8'hAA);
        check_outputs("R4 lock");
        bus_read("R4 locked read", 16'h002F);
        bus_write(16'h002E, 8'h55);
        bus_write(16'h002E, 8'h61);
        bus_read("R4 contents kept", 16'h002F);

        // Constrained random phase
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int ra, rd_sel;
            ra = $urandom % 8;
            rd_sel = $urandom % 11;
            if (ra < 4) a = 16'h002E;
            else if (ra < 7) a = 16'h002F;
            else a = 16'($urandom);
            case (rd_sel)
                0: d = 8'h55;
                1: d = 8'hAA;
                2: d = 8'h07;
                3: d = 8'h08;
                4: d = 8'h60;
                5: d = 8'h61;
                6: d = 8'h20;
                7: d = 8'h21;
                default: d = 8'($urandom);
            endcase
            if (($urandom % 10) < 6) begin
                bus_write(a, d);
                check_outputs("R2 R3 R4 R8 R9 random write");
            end else begin
                bus_read("R5 R6 R7 R10 random read", a);
            end
        end

        finish_run();
    end
endmodule